// File: doc/BRIEF.md
# Dual-Structure 16-bit Pseudo-Random Sequence Generator

This block produces a pseudo-random bit stream from a 16-bit linear-feedback shift register. The register moves forward by one state on every clock in which the enable input is high. Its feedback polynomial is x^16 + x^14 + x^13 + x^11 + 1, so any nonzero starting value runs through all 65535 nonzero states before it repeats. A static parameter selects one of two structures for the same polynomial. The external-XOR form collects the tap bits into a single feedback bit. The internal-XOR form applies a toggle mask to the shifted register whenever the bit shifted out is 1.

Software or a neighbouring block can load a new starting value with a one-cycle strobe. An all-zero value would lock the register, so a load of zero is replaced by 0x0001. The block gives out the full state and a serial bit, which is the state's least significant bit. It also raises a one-cycle pulse on the step that brings the state back to the most recently loaded starting value, which marks the end of a full period.

Top module: `lfsr16_gen`

## Requirements
- R1: A synchronous reset sets the state to 0xACE1, makes 0xACE1 the reference seed, and drives the wrap pulse low.
- R2: In the external-XOR form (INTERNAL_XOR=0), one step shifts the state right by one bit and puts the XOR of state bits 0, 2, 3 and 5 into bit 15. From 0xACE1 the next state is 0x5670.
- R3: In the internal-XOR form (INTERNAL_XOR=1), one step shifts the state right by one bit and then XORs the result with 0xB400 if the bit shifted out was 1. From 0xACE1 the next state is 0xE270.
- R4: From any nonzero seed, the state returns to that seed after exactly 65535 steps and is never zero along the way.
- R5: The serial output always equals bit 0 of the state output.
- R6: While enable is low and no load is requested, the state holds its value and the wrap pulse stays low.
- R7: A load strobe with a nonzero seed makes the state equal that seed on the next cycle. The load takes priority over enable, and the loaded value becomes the reference seed.
- R8: A load strobe with an all-zero seed loads 0x0001 instead, and 0x0001 becomes the reference seed.
- R9: The wrap pulse is high for exactly one cycle. It goes high in the cycle after a step whose new state equals the reference seed, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one state on this clock |
| loadStb | input | 1 | Load seedIn as the new state and reference seed |
| seedIn | input | 16 | Seed value used by loadStb |
| stateOut | output | 16 | Current register state |
| serialOut | output | 1 | Serial output bit (state bit 0) |
| wrapPulse | output | 1 | One-cycle flag marking the return to the reference seed |

## Verification
Both structures run side by side from the same inputs. Each one is walked through its whole 65535-state period twice. The first walk starts from the reset value 0xACE1; the second starts from 0x0001, the value that replaces a zero-seed load. Comparing every step against an arithmetic model separates a wrong tap or mask from a correct one. The second walk confirms that the wrap detection follows the loaded seed and is not fixed to the reset value. Separate short patterns cover load priority over enable, holding while idle, and the one-cycle width of the wrap pulse.

// File: rtl/lfsr16_pkg.sv
package lfsr16_pkg;
  localparam int STATE_W = 16;
  typedef logic [STATE_W-1:0] state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   step;
    state_t seedVal;
  } lfsr_strobe_t;
endpackage

// File: rtl/lfsr16_ctrl.sv
module lfsr16_ctrl
  import lfsr16_pkg::*;
#(
  parameter state_t FALLBACK_SEED = state_t'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         loadStb,
  input  state_t       seedIn,
  output lfsr_strobe_t strobe
);
  logic seedIsZero;

  assign seedIsZero = (seedIn == '0);

  always_comb begin
    strobe.load    = loadStb;
    strobe.step    = en & ~loadStb;
    strobe.seedVal = seedIsZero ? FALLBACK_SEED : seedIn;
  end

  // R8: a load never carries a zero seed into the datapath
  p_seed_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.load |-> (strobe.seedVal != '0));

  // R7: load and step are never requested together
  p_load_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load && strobe.step));
endmodule

// File: rtl/lfsr16_datapath.sv
module lfsr16_datapath
  import lfsr16_pkg::*;
#(
  parameter bit     INTERNAL_XOR = 1'b0,
  parameter state_t TAP_MASK     = 16'h002D,
  parameter state_t TOGGLE_MASK  = 16'hB400,
  parameter state_t RESET_SEED   = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  lfsr_strobe_t strobe,
  output state_t       stateQ,
  output logic         wrapQ
);
  localparam int MSB = STATE_W - 1;

  state_t seedQ;
  state_t nextState;

  generate
    if (INTERNAL_XOR) begin : g_internal
      state_t shifted;
      assign shifted   = {1'b0, stateQ[MSB:1]};
      assign nextState = stateQ[0] ? (shifted ^ TOGGLE_MASK) : shifted;
    end else begin : g_external
      logic feedBit;
      assign feedBit   = ^(stateQ & TAP_MASK);
      assign nextState = {feedBit, stateQ[MSB:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= RESET_SEED;
      seedQ  <= RESET_SEED;
      wrapQ  <= 1'b0;
    end else if (strobe.load) begin
      stateQ <= strobe.seedVal;
      seedQ  <= strobe.seedVal;
      wrapQ  <= 1'b0;
    end else if (strobe.step) begin
      stateQ <= nextState;
      wrapQ  <= (nextState == seedQ);
    end else begin
      wrapQ  <= 1'b0;
    end
  end

  // R4: the register never reaches the lock-up state
  p_never_zero_r4: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);

  // R6: idle cycles leave the state untouched
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.step) |=> $stable(stateQ));

  // R7: a load lands on the next cycle
  p_load_lands_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (stateQ == $past(strobe.seedVal)));

  // R9: the pulse lasts one cycle and marks the reference seed
  p_wrap_single_r9: assert property (@(posedge clk) disable iff (rst)
    wrapQ |=> !wrapQ);
  p_wrap_at_seed_r9: assert property (@(posedge clk) disable iff (rst)
    wrapQ |-> (stateQ == seedQ));
endmodule

// File: rtl/lfsr16_gen.sv
module lfsr16_gen
  import lfsr16_pkg::*;
#(
  parameter bit INTERNAL_XOR = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        loadStb,
  input  logic [15:0] seedIn,
  output logic [15:0] stateOut,
  output logic        serialOut,
  output logic        wrapPulse
);
  lfsr_strobe_t strobe;
  state_t       stateQ;
  logic         wrapQ;

  lfsr16_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .loadStb (loadStb),
    .seedIn  (seedIn),
    .strobe  (strobe)
  );

  lfsr16_datapath #(
    .INTERNAL_XOR (INTERNAL_XOR)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .stateQ (stateQ),
    .wrapQ  (wrapQ)
  );

  assign stateOut  = stateQ;
  assign serialOut = stateQ[0];  // R5
  assign wrapPulse = wrapQ;
endmodule

// File: tb/lfsr16_gen_bench.sv
module lfsr16_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_LEN = 65535;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] seedIn = '0;
  logic [15:0] stateE, stateI;
  logic        serE, serI, wrapE, wrapI;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr16_gen #(.INTERNAL_XOR(1'b0)) u_lfsr16_gen (
    .clk(clk), .rst(rst), .en(en), .loadStb(loadStb), .seedIn(seedIn),
    .stateOut(stateE), .serialOut(serE), .wrapPulse(wrapE));

  lfsr16_gen #(.INTERNAL_XOR(1'b1)) u_lfsr16_gen_int (
    .clk(clk), .rst(rst), .en(en), .loadStb(loadStb), .seedIn(seedIn),
    .stateOut(stateI), .serialOut(serI), .wrapPulse(wrapI));

  function automatic logic [15:0] extNext(logic [15:0] s);
    logic b;
    b = s[0] ^ s[2] ^ s[3] ^ s[5];
    return {b, s[15:1]};
  endfunction

  function automatic logic [15:0] intNext(logic [15:0] s);
    logic [15:0] t;
    t = s >> 1;
    if (s[0]) t = t ^ 16'hB400;
    return t;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change 1 time unit after a rising edge; outputs read there too
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // full-period walk of both structures from a common seed
  task automatic fullWalk(logic [15:0] seed, string tag);
    logic [15:0] mE = seed;
    logic [15:0] mI = seed;
    int errE = 0, errI = 0, errS = 0, errW = 0, zeroSeen = 0;
    en = 1'b1;
    for (int k = 1; k <= PERIOD_LEN; k++) begin
      tick();
      mE = extNext(mE);
      mI = intNext(mI);
      if (stateE !== mE) errE++;
      if (stateI !== mI) errI++;
      if (serE !== stateE[0] || serI !== stateI[0]) errS++;
      if (wrapE !== (k == PERIOD_LEN) || wrapI !== (k == PERIOD_LEN)) errW++;
      if (stateE == 16'h0 || stateI == 16'h0) zeroSeen++;
    end
    check({"R2 external walk mismatches ", tag}, errE, 0);
    check({"R3 internal walk mismatches ", tag}, errI, 0);
    check({"R5 serial mismatches ", tag}, errS, 0);
    check({"R9 wrap timing errors ", tag}, errW, 0);
    check({"R4 zero state seen ", tag}, zeroSeen, 0);
    check({"R4 external back at seed ", tag}, stateE, seed);
    check({"R4 internal back at seed ", tag}, stateI, seed);
  endtask

  initial begin
    logic [15:0] heldE, heldI;
    tick();
    tick();
    // R1: reset state
    check("R1 external reset state", stateE, 16'hACE1);
    check("R1 internal reset state", stateI, 16'hACE1);
    check("R1 wrap low in reset", {wrapE, wrapI}, 0);
    rst = 1'b0;
    tick();
    check("R6 no step without enable", stateE, 16'hACE1);

    // R2/R3: single known step, then the rest of the period from 0xACE1
    en = 1'b1;
    tick();
    check("R2 ACE1 -> 5670", stateE, 16'h5670);
    check("R3 ACE1 -> E270", stateI, 16'hE270);
    check("R5 serial bits", {serE, serI}, {stateE[0], stateI[0]});
    en = 1'b0;
    tick();
    // R6: hold while idle
    heldE = stateE;
    heldI = stateI;
    tick();
    tick();
    check("R6 external holds", stateE, heldE);
    check("R6 internal holds", stateI, heldI);
    check("R6 wrap low while idle", {wrapE, wrapI}, 0);

    // R7: load takes priority over enable
    seedIn = 16'hACE1;
    loadStb = 1'b1;
    en = 1'b1;
    tick();
    loadStb = 1'b0;
    check("R7 external loaded", stateE, 16'hACE1);
    check("R7 internal loaded", stateI, 16'hACE1);
    check("R9 no wrap on load", {wrapE, wrapI}, 0);
    fullWalk(16'hACE1, "seed ACE1");
    // R9: pulse drops after one cycle
    tick();
    check("R9 external pulse one cycle", wrapE, 0);
    check("R9 internal pulse one cycle", wrapI, 0);
    check("R2 step after wrap", stateE, 16'h5670);

    // R7: arbitrary nonzero load, then one step
    seedIn = 16'h1234;
    loadStb = 1'b1;
    tick();
    loadStb = 1'b0;
    check("R7 load 1234 external", stateE, 16'h1234);
    check("R7 load 1234 internal", stateI, 16'h1234);
    tick();
    check("R2 step from 1234", stateE, extNext(16'h1234));
    check("R3 step from 1234", stateI, intNext(16'h1234));

    // R8: zero seed replaced, walk confirms new reference seed
    seedIn = 16'h0000;
    loadStb = 1'b1;
    tick();
    loadStb = 1'b0;
    check("R8 zero seed external", stateE, 16'h0001);
    check("R8 zero seed internal", stateI, 16'h0001);
    fullWalk(16'h0001, "seed 0001");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule